// File: doc/BRIEF.md
# Reconfigurable Parallel-Prefix Carry Network

This block is the fast carry resource that sits beside a column of programmable logic cells. Each cell hands it a pair of bits describing what that cell's carry-out should be: one bit for a carry-in of one, the other for a carry-in of zero. Together the two bits encode one of four carry behaviours: force low, force high, pass the incoming carry, or pass it inverted. The inverted case lets the same chain carry parity and comparison chains as well as ordinary addition.

A logarithmic tree of two-input combining boxes builds, for every cell, the composite behaviour of all cells from the bottom of the column up to and including it. A final row of 2:1 selectors then turns the chain carry-in into each cell's carry-out in one step. A user who wants several independent chains in one column simply programs a cell with both bits equal. That cell's output then no longer depends on anything below it, so a new chain starts there with no further setup. The width is a power of two. An optional register stage, chosen by a parameter, holds the outputs for one clock.

Top module: `prefix_carry_net`

## Requirements
- R1: With `OUT_REG` = 1, the clock edge after `rst` is sampled high drives `cout` to all zeros.
- R2: Cell i's state is the bit pair (`cell_hi[i]`, `cell_lo[i]`): 0,0 forces the cell's carry-out to 0; 1,1 forces it to 1; 1,0 passes the carry from below; 0,1 passes it inverted. The carry from below is `cin` for cell 0 and `cout[i-1]` otherwise.
- R3: For any input pattern, `cout[i]` equals the value got by rippling `cin` through cells 0 to i one at a time under the rules of R2.
- R4: When every cell is in the pass state (1,0), every bit of `cout` equals `cin`.
- R5: When every cell is in pass or inverting pass, `cout[i]` equals `cin` XOR the parity of the number of inverting cells among cells 0 to i.
- R6: A cell whose two bits are equal sets its carry-out to that bit value. Neither `cin` nor any cell below it has any effect on it or on any output above it.
- R7: With `OUT_REG` = 1, `cout` reflects the inputs present at the previous rising clock edge and does not change between edges. With `OUT_REG` = 0 it follows the inputs combinationally.
- R8: `WIDTH` is a power of two of at least 2. The result of R3 holds for every cell of such a width, including the top cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cell_hi | input | WIDTH | Per-cell carry-out value assuming an incoming carry of 1 |
| cell_lo | input | WIDTH | Per-cell carry-out value assuming an incoming carry of 0 |
| cin | input | 1 | Carry into cell 0 |
| cout | output | WIDTH | Per-cell carry-out |

## Verification
The bench targets inverting-pass cells, where a generate/propagate-only operator would lose the inversion and leave parity outputs wrong. It drives long all-pass chains, where a missing down-sweep node would leave mid-column cells without the full prefix while the top cell still looks correct. Split columns are set by programming equal bit pairs. The bench checks that a design leaking `cin` or lower cells across the split shows different upper outputs when only the lower segment changes. It also samples between clock edges to catch an output that moves one cycle early or late.

// File: rtl/pc_pkg.sv
package pc_pkg;

    // Carry behaviour of one cell or of a span of cells.
    typedef struct packed {
        logic on_one;   // carry-out when the incoming carry is 1
        logic on_zero;  // carry-out when the incoming carry is 0
    } cstate_t;

    // Compose an upper span with the span directly beneath it.
    function automatic cstate_t cs_join(cstate_t upper, cstate_t lower);
        cstate_t r;
        r.on_one  = lower.on_one  ? upper.on_one : upper.on_zero;
        r.on_zero = lower.on_zero ? upper.on_one : upper.on_zero;
        return r;
    endfunction

    // Resolve a span's carry-out once its incoming carry is known.
    function automatic logic cs_resolve(cstate_t s, logic c);
        return c ? s.on_one : s.on_zero;
    endfunction

endpackage

// File: rtl/pc_concat_box.sv
module pc_concat_box
    import pc_pkg::*;
(
    input  cstate_t upper,
    input  cstate_t lower,
    output cstate_t joined
);
    assign joined = cs_join(upper, lower);
endmodule

// File: rtl/pc_prefix_tree.sv
module pc_prefix_tree
    import pc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  cstate_t [WIDTH-1:0] cells,
    output cstate_t [WIDTH-1:0] prefix
);
    localparam int LVL    = $clog2(WIDTH);
    localparam int STAGES = 2 * LVL;

    cstate_t [WIDTH-1:0] node [0:STAGES-1];

    assign node[0] = cells;

    // Up-sweep: each level doubles the span held at selected positions.
    for (genvar u = 0; u < LVL; u++) begin : g_up
        localparam int STEP = 2 ** u;
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            if (((i + 1) % (2 * STEP)) == 0) begin : g_box
                pc_concat_box u_box (
                    .upper (node[u][i]),
                    .lower (node[u][i-STEP]),
                    .joined(node[u+1][i])
                );
            end else begin : g_pass
                assign node[u+1][i] = node[u][i];
            end
        end
    end

    // Down-sweep: fill the positions the up-sweep left with partial spans.
    for (genvar d = 0; d < LVL - 1; d++) begin : g_down
        localparam int SP = 2 ** (LVL - 2 - d);
        localparam int ST = LVL + d;
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            if ((((i + 1) % (2 * SP)) == SP) && ((i + 1) > 2 * SP)) begin : g_box
                pc_concat_box u_box (
                    .upper (node[ST][i]),
                    .lower (node[ST][i-SP]),
                    .joined(node[ST+1][i])
                );
            end else begin : g_pass
                assign node[ST+1][i] = node[ST][i];
            end
        end
    end

    assign prefix = node[STAGES-1];
endmodule

// File: rtl/pc_out_stage.sv
module pc_out_stage
    import pc_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cstate_t [WIDTH-1:0]  prefix,
    input  logic                 cin,
    output logic    [WIDTH-1:0]  cout
);
    logic [WIDTH-1:0] resolved;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            resolved[i] = cs_resolve(prefix[i], cin);
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) cout <= '0;
            else     cout <= resolved;
        end
    end else begin : g_comb
        assign cout = resolved;
    end
endmodule

// File: rtl/prefix_carry_net.sv
module prefix_carry_net
    import pc_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cell_hi,
    input  logic [WIDTH-1:0] cell_lo,
    input  logic             cin,
    output logic [WIDTH-1:0] cout
);
    initial begin
        if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0)
            $error("prefix_carry_net: WIDTH must be a power of two >= 2");
    end

    cstate_t [WIDTH-1:0] cells;
    cstate_t [WIDTH-1:0] prefix;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            cells[i].on_one  = cell_hi[i];
            cells[i].on_zero = cell_lo[i];
        end
    end

    pc_prefix_tree #(.WIDTH(WIDTH)) u_tree (
        .cells (cells),
        .prefix(prefix)
    );

    pc_out_stage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst   (rst),
        .prefix(prefix),
        .cin   (cin),
        .cout  (cout)
    );
endmodule

// File: rtl/pc_net_checker.sv
module pc_net_checker #(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] cell_hi,
    input logic [WIDTH-1:0] cell_lo,
    input logic             cin,
    input logic [WIDTH-1:0] cout
);
    // Serial reference: one cell at a time.
    logic [WIDTH-1:0] ref_v;
    always_comb begin
        logic c;
        c = cin;
        for (int i = 0; i < WIDTH; i++) begin
            c = c ? cell_hi[i] : cell_lo[i];
            ref_v[i] = c;
        end
    end

    if (OUT_REG) begin : g_reg
        logic armed;
        always_ff @(posedge clk) begin
            if (rst) armed <= 1'b0;
            else     armed <= 1'b1;
        end

        a_r1_reset_clears: assert property (@(posedge clk)
            rst |=> (cout == '0));

        a_r3_matches_ripple: assert property (@(posedge clk) disable iff (rst)
            armed |-> (cout == $past(ref_v)));

        a_r4_all_pass: assert property (@(posedge clk) disable iff (rst)
            (armed && $past(cell_hi == '1 && cell_lo == '0))
                |-> (cout == {WIDTH{$past(cin)}}));

        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            a_r6_fixed_cell: assert property (@(posedge clk) disable iff (rst)
                (armed && $past(cell_hi[i] == cell_lo[i]))
                    |-> (cout[i] == $past(cell_hi[i])));
            if (i > 0) begin : g_link
                a_r2_cell_link: assert property (@(posedge clk) disable iff (rst)
                    armed |-> (cout[i] == (cout[i-1] ? $past(cell_hi[i])
                                                     : $past(cell_lo[i]))));
            end
        end
    end else begin : g_comb
        always @(negedge clk) begin
            if (!rst) begin
                a_r3_comb_ripple: assert (cout == ref_v)
                    else $error("R3 combinational mismatch");
            end
        end
    end
endmodule

bind prefix_carry_net pc_net_checker #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cell_hi(cell_hi),
    .cell_lo(cell_lo),
    .cin    (cin),
    .cout   (cout)
);

// File: tb/prefix_carry_net_test.sv
module prefix_carry_net_test;
    localparam int W      = 16;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cell_hi = '0;
    logic [W-1:0] cell_lo = '0;
    logic         cin = 1'b0;
    logic [W-1:0] cout;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    prefix_carry_net #(.WIDTH(W), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst(rst), .cell_hi(cell_hi), .cell_lo(cell_lo),
        .cin(cin), .cout(cout)
    );

    function automatic logic [W-1:0] ripple(logic [W-1:0] h, logic [W-1:0] l, logic c);
        logic [W-1:0] r;
        logic x;
        x = c;
        for (int i = 0; i < W; i++) begin
            x = x ? h[i] : l[i];
            r[i] = x;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; the output is registered at the next rising
    // edge and sampled at the falling edge after it.
    task automatic apply(logic [W-1:0] h, logic [W-1:0] l, logic c);
        @(negedge clk);
        cell_hi = h; cell_lo = l; cin = c;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cell_hi = '1; cell_lo = '1; cin = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 reset clears outputs", cout, '0);
        rst = 1'b0;
    endtask

    task automatic t_states();
        apply('0, '0, 1'b1);
        check("R2 kill everywhere", cout, '0);
        apply('1, '1, 1'b0);
        check("R2 generate everywhere", cout, '1);
        apply(16'h0001, 16'h0000, 1'b1);
        check("R2 pass at cell 0 then kill", cout, 16'h0001);
        apply(16'h0000, 16'h0001, 1'b0);
        check("R2 invert at cell 0 then kill", cout, 16'h0001);
    endtask

    task automatic t_propagate();
        apply('1, '0, 1'b1);
        check("R4 all pass cin=1", cout, '1);
        apply('1, '0, 1'b0);
        check("R4 all pass cin=0", cout, '0);
    endtask

    task automatic t_inverse();
        logic [W-1:0] inv;
        logic [W-1:0] exp;
        logic p;
        for (int k = 0; k < 4; k++) begin
            inv = (k == 0) ? 16'h0001 : (k == 1) ? 16'h8000 :
                  (k == 2) ? 16'hAAAA : 16'h1357;
            for (int c = 0; c < 2; c++) begin
                p = c[0];
                for (int i = 0; i < W; i++) begin
                    p = p ^ inv[i];
                    exp[i] = p;
                end
                apply(~inv, inv, c[0]);
                check("R5 inverting pass parity", cout, exp);
            end
        end
    endtask

    task automatic t_segments();
        logic [W-1:0] h, l, first, second;
        // Cell 8 fixed to 1 splits the column.
        h = 16'hFF00 | 16'h00F0; l = 16'h0100 | 16'h000F;
        apply(h, l, 1'b0);
        first = cout;
        check("R6 split cell value", {15'b0, cout[8]}, 16'h0001);
        apply(h ^ 16'h00FF, l ^ 16'h00FF, 1'b1);
        second = cout;
        check("R6 upper segment unaffected by lower cells and cin",
              {8'b0, second[15:8]}, {8'b0, first[15:8]});
        check("R6 segmented against ripple", second, ripple(h ^ 16'h00FF, l ^ 16'h00FF, 1'b1));
        apply(16'h0001, 16'h0001, 1'b0);
        check("R6 cell 0 fixed ignores cin", cout, 16'h0001);
    endtask

    task automatic t_latency();
        logic [W-1:0] prev;
        apply('1, '0, 1'b0);
        prev = cout;
        @(negedge clk);
        cell_hi = '1; cell_lo = '0; cin = 1'b1;
        #1;
        check("R7 output holds until next edge", cout, prev);
        @(negedge clk);
        check("R7 output updates one edge later", cout, '1);
    endtask

    task automatic t_random();
        logic [W-1:0] h, l, m;
        for (int n = 0; n < 200; n++) begin
            h = W'($urandom); l = W'($urandom);
            if (n % 2 == 1) begin
                m = W'($urandom) & W'($urandom);
                h = (h & ~m) | (l & m);
            end
            apply(h, l, n[2]);
            check("R3 random against ripple", cout, ripple(h, l, n[2]));
        end
        apply(16'h7FFF, 16'h8000, 1'b1);
        check("R8 top cell inverts full chain", cout, ripple(16'h7FFF, 16'h8000, 1'b1));
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_states();
        t_propagate();
        t_inverse();
        t_segments();
        t_latency();
        t_random();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule